// File: doc/BRIEF.md
# Cache Bypass Decision Unit

This unit sits beside a DRAM cache that fronts a slower storage-class memory. When a line misses in the DRAM cache, the demand access is already being served from the slow memory. This unit decides afterwards, off the critical path, whether the line should be installed in DRAM or should bypass it. Each miss arrives with a small set of statistics: a read count, a write count, a spatial-locality hint and a hotness counter. From these the unit forms a 4-bit utility score.

The decision has two levels. Level 1 compares the score against a running exponential average of past scores, widened by a margin on each side. A score clearly below the band bypasses, and a score clearly above it installs. A score inside the band is ambiguous, so the unit issues a probe for the victim line's metadata. Once the victim's stored score returns, the line is installed only if its own score beats the victim's. Because the average follows the recent score mix, most misses settle at Level 1 and probe traffic stays low. The unit counts how many decisions each level completed.

The request input and the decision output each use a valid/ready handshake. The unit holds at most one miss at a time, from acceptance until its decision is taken.

Top module: `byp_decide_unit`

## Requirements
- R1: After reset, req_ready is 1, probe_valid and dec_valid are 0, both decision counters are 0 and thr_level equals INIT_LEVEL (default 8).
- R2: The score is min((reads + hot + 2*spatial + W) >> 2, 15), where W = 2*writes when score_rw is 1 and W = 0 when score_rw is 0. In reads-only mode the write count has no effect on dec_score or on the decision. The result appears on dec_score.
- R3: When score + MARGIN < level (default MARGIN 2), no probe is issued, and the decision has dec_install = 0 (bypass) and dec_probed = 0.
- R4: When score > level + MARGIN, no probe is issued, and the decision has dec_install = 1 and dec_probed = 0.
- R5: Any other score raises probe_valid in the cycle after acceptance. probe_valid holds until probe_ready, and no decision is presented before a victim response.
- R6: After a probe, the first victim_valid sets dec_install = 1 exactly when score > victim_score, and sets dec_probed = 1.
- R7: The average is kept with 3 fraction bits as avg. On each accepted decision, avg becomes avg - (avg >> 3) + score, and thr_level = avg >> 3. thr_level changes at no other time.
- R8: req_ready is 1 only while no miss is held. A presented decision keeps dec_valid, dec_install, dec_probed and dec_score stable until dec_ready. Among req_ready, probe_valid and dec_valid, at most one is 1 at any time.
- R9: l1_count increments by one on each accepted decision with dec_probed = 0. l2_count increments by one on each accepted decision with dec_probed = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| score_rw | input | 1 | 1: writes add to the score; 0: reads-only scoring |
| req_valid | input | 1 | Miss statistics valid |
| req_ready | output | 1 | Unit can accept a miss |
| req_reads | input | CNT_W | Read count of the missing line |
| req_writes | input | CNT_W | Write count of the missing line |
| req_hot | input | CNT_W | Hotness counter |
| req_spatial | input | SPAT_W | Spatial-locality hint |
| probe_valid | output | 1 | Victim-metadata probe request |
| probe_ready | input | 1 | Probe accepted |
| victim_valid | input | 1 | Victim score returned |
| victim_score | input | SCORE_W | Stored score of the victim line |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Decision consumed |
| dec_install | output | 1 | 1: install in DRAM, 0: bypass |
| dec_probed | output | 1 | Decision was made at Level 2 |
| dec_score | output | SCORE_W | Score of the decided line |
| thr_level | output | SCORE_W | Integer part of the moving average |
| l1_count | output | STAT_W | Level-1 decisions taken |
| l2_count | output | STAT_W | Level-2 decisions taken |

## Verification
The hardest situation to reach is a score that lands exactly on either edge of the margin band, or just outside it. The band moves whenever a decision updates the average. The bench therefore tracks the average arithmetically and, on every other miss, builds the statistics backwards from a target score of level + d, for d from -3 to +3. This covers both band edges, both sides of each edge and the Level-2 victim comparison. Probe, response and decision delays are varied so that the holding rules are exercised while the unit waits.

// File: rtl/byp_pkg.sv
package byp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } byp_state_e;
endpackage

// File: rtl/byp_score.sv
module byp_score #(
  parameter int CNT_W   = 4,
  parameter int SPAT_W  = 2,
  parameter int SCORE_W = 4,
  parameter int SHIFT   = 2
) (
  input  logic               rw_mode,
  input  logic [CNT_W-1:0]   reads,
  input  logic [CNT_W-1:0]   writes,
  input  logic [CNT_W-1:0]   hot,
  input  logic [SPAT_W-1:0]  spatial,
  output logic [SCORE_W-1:0] score
);
  localparam int BASE_W  = (CNT_W > SPAT_W) ? CNT_W : SPAT_W;
  localparam int RAW_W   = BASE_W + 3;
  localparam int MAX_VAL = (1 << SCORE_W) - 1;

  logic [RAW_W-1:0] raw;
  logic [RAW_W-1:0] wterm;
  logic [RAW_W-1:0] shifted;

  always_comb begin
    wterm   = rw_mode ? (RAW_W'(writes) << 1) : '0;
    raw     = RAW_W'(reads) + RAW_W'(hot) + (RAW_W'(spatial) << 1) + wterm;
    shifted = raw >> SHIFT;
    if (shifted > RAW_W'(MAX_VAL)) score = SCORE_W'(MAX_VAL);
    else                           score = shifted[SCORE_W-1:0];
  end
endmodule

// File: rtl/byp_level_avg.sv
module byp_level_avg #(
  parameter int SCORE_W    = 4,
  parameter int AVG_FRAC   = 3,
  parameter int INIT_LEVEL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic [SCORE_W-1:0] upd_score,
  output logic [SCORE_W-1:0] level
);
  localparam int AVG_W = SCORE_W + AVG_FRAC;

  logic [AVG_W-1:0] avg_q;
  logic [AVG_W-1:0] avg_d;
  logic [AVG_W:0]   sum;

  always_comb begin
    sum   = {1'b0, avg_q} - {1'b0, (avg_q >> AVG_FRAC)} + (AVG_W+1)'(upd_score);
    avg_d = avg_q;
    if (upd_en) avg_d = sum[AVG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avg_q <= AVG_W'(INIT_LEVEL << AVG_FRAC);
    else        avg_q <= avg_d;
  end

  assign level = avg_q[AVG_W-1:AVG_FRAC];
endmodule

// File: rtl/byp_stats.sv
module byp_stats #(
  parameter int NUM    = 2,
  parameter int STAT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM-1:0]               inc,
  output logic [NUM-1:0][STAT_W-1:0]   counts
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [STAT_W-1:0] cnt_q;
    logic [STAT_W-1:0] cnt_d;
    always_comb begin
      cnt_d = cnt_q;
      if (inc[g]) cnt_d = cnt_q + STAT_W'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end
    assign counts[g] = cnt_q;
  end
endmodule

// File: rtl/byp_decide_unit.sv
module byp_decide_unit
  import byp_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SPAT_W     = 2,
  parameter int SCORE_W    = 4,
  parameter int SHIFT      = 2,
  parameter int AVG_FRAC   = 3,
  parameter int INIT_LEVEL = 8,
  parameter int MARGIN     = 2,
  parameter int STAT_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               score_rw,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CNT_W-1:0]   req_reads,
  input  logic [CNT_W-1:0]   req_writes,
  input  logic [CNT_W-1:0]   req_hot,
  input  logic [SPAT_W-1:0]  req_spatial,
  output logic               probe_valid,
  input  logic               probe_ready,
  input  logic               victim_valid,
  input  logic [SCORE_W-1:0] victim_score,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic               dec_install,
  output logic               dec_probed,
  output logic [SCORE_W-1:0] dec_score,
  output logic [SCORE_W-1:0] thr_level,
  output logic [STAT_W-1:0]  l1_count,
  output logic [STAT_W-1:0]  l2_count
);
  localparam int CMP_W = SCORE_W + 2;

  byp_state_e         state_q, state_d;
  logic [SCORE_W-1:0] score_q, score_d;
  logic               install_q, install_d;
  logic               probed_q, probed_d;
  logic [SCORE_W-1:0] new_score;
  logic               below_band, above_band;
  logic               dec_fire;
  logic [1:0][STAT_W-1:0] stat_counts;

  byp_score #(
    .CNT_W(CNT_W), .SPAT_W(SPAT_W), .SCORE_W(SCORE_W), .SHIFT(SHIFT)
  ) u_score (
    .rw_mode(score_rw),
    .reads(req_reads),
    .writes(req_writes),
    .hot(req_hot),
    .spatial(req_spatial),
    .score(new_score)
  );

  always_comb begin
    below_band = (CMP_W'(new_score) + CMP_W'(MARGIN)) < CMP_W'(thr_level);
    above_band = CMP_W'(new_score) > (CMP_W'(thr_level) + CMP_W'(MARGIN));
  end

  always_comb begin
    state_d   = state_q;
    score_d   = score_q;
    install_d = install_q;
    probed_d  = probed_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          score_d = new_score;
          if (below_band) begin
            install_d = 1'b0;
            probed_d  = 1'b0;
            state_d   = ST_DONE;
          end else if (above_band) begin
            install_d = 1'b1;
            probed_d  = 1'b0;
            state_d   = ST_DONE;
          end else begin
            probed_d  = 1'b1;
            state_d   = ST_PROBE;
          end
        end
      end
      ST_PROBE: begin
        if (probe_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (victim_valid) begin
          install_d = score_q > victim_score;
          state_d   = ST_DONE;
        end
      end
      ST_DONE: begin
        if (dec_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      score_q   <= '0;
      install_q <= 1'b0;
      probed_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      score_q   <= score_d;
      install_q <= install_d;
      probed_q  <= probed_d;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign probe_valid = (state_q == ST_PROBE);
  assign dec_valid   = (state_q == ST_DONE);
  assign dec_install = install_q;
  assign dec_probed  = probed_q;
  assign dec_score   = score_q;
  assign dec_fire    = dec_valid && dec_ready;

  byp_level_avg #(
    .SCORE_W(SCORE_W), .AVG_FRAC(AVG_FRAC), .INIT_LEVEL(INIT_LEVEL)
  ) u_avg (
    .clk(clk),
    .rst_n(rst_n),
    .upd_en(dec_fire),
    .upd_score(score_q),
    .level(thr_level)
  );

  byp_stats #(.NUM(2), .STAT_W(STAT_W)) u_stats (
    .clk(clk),
    .rst_n(rst_n),
    .inc({dec_fire && probed_q, dec_fire && !probed_q}),
    .counts(stat_counts)
  );

  assign l1_count = stat_counts[0];
  assign l2_count = stat_counts[1];
endmodule

// File: rtl/byp_decide_checker.sv
module byp_decide_checker #(
  parameter int SCORE_W = 4,
  parameter int STAT_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               probe_valid,
  input logic               probe_ready,
  input logic               dec_valid,
  input logic               dec_ready,
  input logic               dec_install,
  input logic               dec_probed,
  input logic [SCORE_W-1:0] dec_score,
  input logic [SCORE_W-1:0] thr_level,
  input logic [STAT_W-1:0]  l1_count,
  input logic [STAT_W-1:0]  l2_count
);
  // R8: at most one handshake phase active
  a_r8_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, probe_valid, dec_valid}));

  // R8: presented decision is held
  a_r8_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_install)
      && $stable(dec_probed) && $stable(dec_score)));

  // R5: probe request held until taken
  a_r5_probe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && !probe_ready) |=> probe_valid);

  // R5: a taken probe is followed by the response wait, not a decision
  a_r5_probe_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_ready) |=> (!dec_valid && !req_ready));

  // R9: Level-1 counter step
  a_r9_l1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && !dec_probed) |=>
      (l1_count == $past(l1_count) + 1'b1) && $stable(l2_count));

  // R9: Level-2 counter step
  a_r9_l2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_probed) |=>
      (l2_count == $past(l2_count) + 1'b1) && $stable(l1_count));

  // R7: level only moves on an accepted decision
  a_r7_level_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && dec_ready) |=> $stable(thr_level));
endmodule

bind byp_decide_unit byp_decide_checker #(
  .SCORE_W(SCORE_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/byp_decide_unit_bench.sv
module byp_decide_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_REQ      = 3000;
  localparam int WD_CYCLES  = 150000;
  localparam int MARGIN     = 2;

  logic       clk;
  logic       rst_n;
  logic       score_rw;
  logic       req_valid;
  logic       req_ready;
  logic [3:0] req_reads, req_writes, req_hot;
  logic [1:0] req_spatial;
  logic       probe_valid, probe_ready;
  logic       victim_valid;
  logic [3:0] victim_score;
  logic       dec_valid, dec_ready, dec_install, dec_probed;
  logic [3:0] dec_score, thr_level;
  logic [15:0] l1_count, l2_count;

  int checks = 0;
  int fails  = 0;
  int avg_m  = 64;
  int cnt1_m = 0;
  int cnt2_m = 0;
  bit done   = 0;

  byp_decide_unit u_byp_decide_unit (
    .clk(clk), .rst_n(rst_n), .score_rw(score_rw),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_reads(req_reads), .req_writes(req_writes),
    .req_hot(req_hot), .req_spatial(req_spatial),
    .probe_valid(probe_valid), .probe_ready(probe_ready),
    .victim_valid(victim_valid), .victim_score(victim_score),
    .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_install(dec_install), .dec_probed(dec_probed),
    .dec_score(dec_score), .thr_level(thr_level),
    .l1_count(l1_count), .l2_count(l2_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int score_of(int r, int w, int h, int s, int m);
    int raw;
    raw = r + h + 2*s + (m != 0 ? 2*w : 0);
    raw = raw / 4;
    return (raw > 15) ? 15 : raw;
  endfunction

  task automatic run_req(input int r, input int w, input int h, input int s,
                         input int m, input int vic, input int pd, input int dd);
    int sc, lvl, exp_inst, exp_prb;
    sc  = score_of(r, w, h, s, m);
    lvl = avg_m / 8;
    if (sc + MARGIN < lvl)      begin exp_inst = 0; exp_prb = 0; end
    else if (sc > lvl + MARGIN) begin exp_inst = 1; exp_prb = 0; end
    else begin exp_prb = 1; exp_inst = (sc > vic) ? 1 : 0; end

    @(negedge clk);
    check("R8 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_reads = 4'(r); req_writes = 4'(w);
    req_hot = 4'(h); req_spatial = 2'(s); score_rw = m[0];
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 busy not ready", int'(req_ready), 0);
    if (exp_prb == 1) begin
      check("R5 probe raised", int'(probe_valid), 1);
      for (int k = 0; k < pd; k++) begin
        @(negedge clk);
        check("R5 probe held", int'(probe_valid), 1);
      end
      probe_ready = 1'b1;
      @(negedge clk);
      probe_ready = 1'b0;
      check("R5 no decision before response", int'(dec_valid), 0);
      @(negedge clk);
      check("R5 still waiting", int'(dec_valid), 0);
      victim_valid = 1'b1; victim_score = 4'(vic);
      @(negedge clk);
      victim_valid = 1'b0;
    end else begin
      if (exp_inst == 1) check("R4 no probe on clear install", int'(probe_valid), 0);
      else               check("R3 no probe on clear bypass", int'(probe_valid), 0);
    end
    for (int k = 0; k < dd; k++) @(negedge clk);
    check("R8 decision valid", int'(dec_valid), 1);
    if (m == 0 && w != 0) check("R2 writes ignored in reads-only mode", int'(dec_score), sc);
    else                  check("R2 score", int'(dec_score), sc);
    check("R6 probed flag", int'(dec_probed), exp_prb);
    if (exp_prb == 1)      check("R6 victim compare", int'(dec_install), exp_inst);
    else if (exp_inst == 1) check("R4 clear install", int'(dec_install), 1);
    else                   check("R3 clear bypass", int'(dec_install), 0);
    dec_ready = 1'b1;
    @(negedge clk);
    dec_ready = 1'b0;
    avg_m = avg_m - (avg_m / 8) + sc;
    if (exp_prb == 1) cnt2_m++; else cnt1_m++;
    check("R7 moving level", int'(thr_level), avg_m / 8);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; score_rw = 1'b0; req_valid = 1'b0;
    req_reads = '0; req_writes = '0; req_hot = '0; req_spatial = '0;
    probe_ready = 1'b0; victim_valid = 1'b0; victim_score = '0;
    dec_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", int'(req_ready), 1);
    check("R1 probe_valid", int'(probe_valid), 0);
    check("R1 dec_valid", int'(dec_valid), 0);
    check("R1 l1_count", int'(l1_count), 0);
    check("R1 l2_count", int'(l2_count), 0);
    check("R1 thr_level", int'(thr_level), 8);

    for (int i = 0; i < N_REQ; i++) begin
      int r, w, h, s, m, t, rem;
      if (i % 2 == 0) begin
        t = avg_m / 8 + ((i / 2) % 7) - 3;
        if (t < 0)  t = 0;
        if (t > 15) t = 15;
        rem = 4 * t;
        r = (rem > 15) ? 15 : rem; rem -= r;
        h = (rem > 15) ? 15 : rem; rem -= h;
        s = (rem / 2 > 3) ? 3 : rem / 2; rem -= 2 * s;
        w = rem / 2;
        m = 1;
      end else begin
        r = (i * 7 + 3) % 16;
        w = (i * 11 + 5) % 16;
        h = (i * 5 + 1) % 16;
        s = (i * 3) % 4;
        m = (i / 3) % 2;
      end
      run_req(r, w, h, s, m, (i * 13) % 16, i % 3, i % 4);
      if (i % 100 == 99) begin
        check("R9 l1_count", int'(l1_count), cnt1_m);
        check("R9 l2_count", int'(l2_count), cnt2_m);
      end
    end
    check("R9 final l1_count", int'(l1_count), cnt1_m);
    check("R9 final l2_count", int'(l2_count), cnt2_m);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule